// File: doc/BRIEF.md
# Word FIFO Pair with Interrupt Unit

This block sits between a serial bus protocol engine and the register bus of a host processor. Software reaches it through six word registers. It writes outgoing words to one address and they queue in an eight-word transmit FIFO. The engine takes each word with a valid/ready handshake. Incoming words from the engine fill an eight-word receive FIFO, and software drains them by reading a single address. Each read of that address removes one word.

A control register holds two flush bits and two trigger levels. Each flush bit clears itself once its FIFO is empty. A status register reports how many transmit slots are free and how many receive words are waiting. Eight sources feed a sticky interrupt status register: the two data requests driven by the trigger levels, receive underflow, transmit overflow, and four engine events. Software clears a status bit by writing 1 to it. A mask register selects which pending bits drive the single interrupt line.

Top module: `fifo_irq_regs`

## Requirements
- R1: Register word addresses are 0 control, 1 status, 2 interrupt mask, 3 interrupt status, 4 transmit data (write), 5 receive data (read). Reading any other address returns 0. After reset the control and mask registers read 0, the status register reads 0x80 and `irq_o` is low.
- R2: Words written to address 4 appear on `tx_word_o` in write order. Each word leaves when `tx_valid_o` and `tx_ready_i` are both high at a clock edge.
- R3: A word on `rx_word_i` is stored when `rx_valid_i` and `rx_ready_o` are both high. Reads of address 5 return stored words in arrival order, one word per read. `rx_ready_o` is low while the receive FIFO holds 8 words.
- R4: Status bits [7:4] give the number of free transmit slots (8 minus the fill). Bits [3:0] give the number of stored receive words.
- R5: Writing 1 to control bit 1 empties the transmit FIFO, and writing 1 to control bit 0 empties the receive FIFO. Each bit reads 1 while its flush runs and reads 0 once that FIFO is empty. Writing 0 to a flush bit does not stop a flush.
- R6: A write to address 4 while the transmit FIFO is full is dropped and sets interrupt status bit 5.
- R7: A read of address 5 while the receive FIFO is empty returns 0 and sets interrupt status bit 4.
- R8: Interrupt status bit 1 (transmit data request) is set in every cycle in which the free-slot count is at or above control bits [7:5].
- R9: Interrupt status bit 0 (receive data request) is set in every cycle in which the receive fill is strictly above control bits [4:2].
- R10: A high level on `ev_arb_lost_i`, `ev_no_ack_i`, `ev_all_done_i` or `ev_pkt_done_i` sets interrupt status bit 2, 3, 6 or 7 respectively. The bit stays set until software clears it.
- R11: Writing to address 3 clears each status bit written as 1 and leaves bits written as 0 unchanged. If a source is active in the same cycle as the clear, its bit stays set.
- R12: `irq_o` is high exactly when some interrupt status bit and the matching mask bit (written at address 2) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register word address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops the receive FIFO at address 5) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| tx_word_o | output | 32 | Head of the transmit FIFO |
| tx_valid_o | output | 1 | Transmit word available |
| tx_ready_i | input | 1 | Engine accepts the transmit word |
| rx_word_i | input | 32 | Word from the engine |
| rx_valid_i | input | 1 | Engine presents a receive word |
| rx_ready_o | output | 1 | Receive FIFO can store a word |
| ev_arb_lost_i | input | 1 | Engine event: arbitration lost |
| ev_no_ack_i | input | 1 | Engine event: no acknowledge |
| ev_all_done_i | input | 1 | Engine event: all packets done |
| ev_pkt_done_i | input | 1 | Engine event: one packet done |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The transmit path is tested with a short burst into an idle engine and with a full eight-word burst. The short burst checks ordering and the free-slot count. The full burst also tries a ninth word, which must be dropped and must not reach the engine. The receive path is tested with a short stream read back in order, with a read of an empty FIFO, and with a fill to capacity, where the ready signal must drop. Trigger levels are moved so that each data request is seen both below and at its threshold. Events are pulsed one at a time and then partly cleared, which shows whether clears are per bit. The mask is stepped between sources to show that the interrupt line follows only enabled pending bits.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned IRQ_N       = 8;
  localparam int unsigned TRIG_W      = 3;
  localparam int unsigned RX_TRIG_LSB = 2;
  localparam int unsigned TX_TRIG_LSB = 5;
  localparam int unsigned FL_RX_BIT   = 0;
  localparam int unsigned FL_TX_BIT   = 1;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_STAT = 3'd1,
    RA_MASK = 3'd2,
    RA_ISTS = 3'd3,
    RA_TXD  = 3'd4,
    RA_RXD  = 3'd5
  } reg_addr_e;

  localparam int unsigned IB_RX_REQ  = 0;
  localparam int unsigned IB_TX_REQ  = 1;
  localparam int unsigned IB_ARB     = 2;
  localparam int unsigned IB_NACK    = 3;
  localparam int unsigned IB_RX_UNF  = 4;
  localparam int unsigned IB_TX_OVF  = 5;
  localparam int unsigned IB_ALL_END = 6;
  localparam int unsigned IB_PKT_END = 7;
endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  assert_push_has_room_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_pop_has_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_fill_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_flush_empties_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         mask_we_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] mask_q, sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      sts_q  <= '0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i;
      // set wins over a same-cycle clear
      sts_q <= (sts_q & ~(clr_we_i ? wdata_i : '0)) | set_i;
    end
  end

  assign mask_o   = mask_q;
  assign status_o = sts_q;
  assign irq_o    = |(sts_q & mask_q);

  assert_clear_per_bit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((sts_q & $past(wdata_i & ~set_i)) == '0));
  assert_set_sticks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((sts_q & $past(set_i)) == $past(set_i)));
  assert_unmasked_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/fifo_irq_regs.sv
module fifo_irq_regs
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic [31:0] tx_word_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  input  logic [31:0] rx_word_i,
  input  logic        rx_valid_i,
  output logic        rx_ready_o,
  input  logic        ev_arb_lost_i,
  input  logic        ev_no_ack_i,
  input  logic        ev_all_done_i,
  input  logic        ev_pkt_done_i,
  output logic        irq_o
);
  logic ctrl_we, mask_we, clr_we, tx_wr, rx_rd;
  logic tx_fl_q, rx_fl_q;
  logic [TRIG_W-1:0] tx_trig_q, rx_trig_q;
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [CNT_W-1:0] tx_cnt, rx_cnt, tx_free;
  logic [WORD_W-1:0] rx_head;
  logic tx_req, rx_req;
  logic [IRQ_N-1:0] irq_set, irq_mask, irq_sts;

  assign ctrl_we = reg_wr_i && (reg_addr_i == RA_CTRL);
  assign mask_we = reg_wr_i && (reg_addr_i == RA_MASK);
  assign clr_we  = reg_wr_i && (reg_addr_i == RA_ISTS);
  assign tx_wr   = reg_wr_i && (reg_addr_i == RA_TXD);
  assign rx_rd   = reg_rd_i && (reg_addr_i == RA_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_fl_q   <= 1'b0;
      rx_fl_q   <= 1'b0;
      tx_trig_q <= '0;
      rx_trig_q <= '0;
    end else begin
      // a flush bit holds until its FIFO reads empty
      tx_fl_q <= (ctrl_we && reg_wdata_i[FL_TX_BIT]) || (tx_fl_q && !tx_empty);
      rx_fl_q <= (ctrl_we && reg_wdata_i[FL_RX_BIT]) || (rx_fl_q && !rx_empty);
      if (ctrl_we) begin
        tx_trig_q <= reg_wdata_i[TX_TRIG_LSB +: TRIG_W];
        rx_trig_q <= reg_wdata_i[RX_TRIG_LSB +: TRIG_W];
      end
    end
  end

  assign tx_push    = tx_wr && !tx_full;
  assign tx_valid_o = !tx_empty && !tx_fl_q;
  assign tx_pop     = tx_valid_o && tx_ready_i;
  assign rx_ready_o = !rx_full && !rx_fl_q;
  assign rx_push    = rx_valid_i && rx_ready_o;
  assign rx_pop     = rx_rd && !rx_empty;

  word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(tx_fl_q),
    .push_i(tx_push), .wdata_i(reg_wdata_i),
    .pop_i(tx_pop), .rdata_o(tx_word_o),
    .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty));

  word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(rx_fl_q),
    .push_i(rx_push), .wdata_i(rx_word_i),
    .pop_i(rx_pop), .rdata_o(rx_head),
    .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty));

  assign tx_free = CNT_W'(DEPTH) - tx_cnt;
  assign tx_req  = 32'(tx_free) >= 32'(tx_trig_q);
  assign rx_req  = 32'(rx_cnt) > 32'(rx_trig_q);

  always_comb begin
    irq_set             = '0;
    irq_set[IB_RX_REQ]  = rx_req;
    irq_set[IB_TX_REQ]  = tx_req;
    irq_set[IB_ARB]     = ev_arb_lost_i;
    irq_set[IB_NACK]    = ev_no_ack_i;
    irq_set[IB_RX_UNF]  = rx_rd && rx_empty;
    irq_set[IB_TX_OVF]  = tx_wr && tx_full;
    irq_set[IB_ALL_END] = ev_all_done_i;
    irq_set[IB_PKT_END] = ev_pkt_done_i;
  end

  irq_unit #(.N(IRQ_N)) u_irq (
    .clk_i, .rst_ni, .set_i(irq_set),
    .mask_we_i(mask_we), .clr_we_i(clr_we), .wdata_i(reg_wdata_i[IRQ_N-1:0]),
    .mask_o(irq_mask), .status_o(irq_sts), .irq_o);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_CTRL: begin
        reg_rdata_o[FL_RX_BIT] = rx_fl_q;
        reg_rdata_o[FL_TX_BIT] = tx_fl_q;
        reg_rdata_o[RX_TRIG_LSB +: TRIG_W] = rx_trig_q;
        reg_rdata_o[TX_TRIG_LSB +: TRIG_W] = tx_trig_q;
      end
      RA_STAT: reg_rdata_o = 32'({tx_free, rx_cnt});
      RA_MASK: reg_rdata_o = 32'(irq_mask);
      RA_ISTS: reg_rdata_o = 32'(irq_sts);
      RA_RXD:  reg_rdata_o = rx_empty ? '0 : rx_head;
      default: reg_rdata_o = '0;
    endcase
  end

  assert_flush_self_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_fl_q && tx_empty && !(ctrl_we && reg_wdata_i[FL_TX_BIT])) |=> !tx_fl_q);
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr && tx_full) |=> (irq_sts[IB_TX_OVF] && $stable(tx_cnt) || $past(tx_pop) || $past(tx_fl_q)));
  assert_underflow_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd && rx_empty) |=> irq_sts[IB_RX_UNF]);
  assert_rx_hold_when_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full |-> !rx_ready_o);
endmodule

// File: tb/sim_fifo_irq_regs.sv
module sim_fifo_irq_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] tx_word;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [31:0] rx_word = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        ev_arb = 1'b0, ev_nack = 1'b0, ev_all = 1'b0, ev_pkt = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_tx[$];
  logic [31:0] exp_rx[$];

  always #10 clk = ~clk;

  fifo_irq_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tx_word_o(tx_word),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .rx_word_i(rx_word),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .ev_arb_lost_i(ev_arb),
    .ev_no_ack_i(ev_nack), .ev_all_done_i(ev_all), .ev_pkt_done_i(ev_pkt),
    .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic tx_send(logic [31:0] d, bit expect_kept);
    reg_write(3'd4, d);
    if (expect_kept) exp_tx.push_back(d);
  endtask

  task automatic rx_feed(logic [31:0] d);
    @(negedge clk);
    rx_word = d; rx_valid = 1'b1;
    if (rx_ready) exp_rx.push_back(d);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_ev(int k);
    @(negedge clk);
    case (k)
      0: ev_arb = 1'b1;
      1: ev_nack = 1'b1;
      2: ev_all = 1'b1;
      default: ev_pkt = 1'b1;
    endcase
    @(negedge clk);
    ev_arb = 1'b0; ev_nack = 1'b0; ev_all = 1'b0; ev_pkt = 1'b0;
  endtask

  // monitor: transmit words leaving the block against the scoreboard
  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      n_chk++;
      if (exp_tx.size() == 0) begin
        n_bad++;
        $display("FAIL R2: unexpected word 0x%08h expected none", tx_word);
      end else begin
        logic [31:0] e;
        e = exp_tx.pop_front();
        if (tx_word !== e) begin
          n_bad++;
          $display("FAIL R2: got 0x%08h expected 0x%08h", tx_word, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset view
    reg_read(3'd0, v); chk("R1 ctrl", v, 32'h0);
    reg_read(3'd1, v); chk("R1 status", v, 32'h80);
    reg_read(3'd2, v); chk("R1 mask", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    reg_read(3'd3, v); chk("R8 tx request at trig 0", v, 32'h02);

    // R2/R4 short burst
    for (int i = 0; i < 3; i++) tx_send(32'hA000_0000 + i, 1'b1);
    reg_read(3'd1, v); chk("R4 free after 3", v, 32'h50);
    @(negedge clk); tx_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 burst drained", exp_tx.size(), 0);
    reg_read(3'd1, v); chk("R4 free restored", v, 32'h80);

    // R6 overflow
    tx_ready = 1'b0;
    for (int i = 0; i < 8; i++) tx_send(32'hB000_0000 + i, 1'b1);
    tx_send(32'hDEAD_BEEF, 1'b0);
    reg_read(3'd1, v); chk("R4 tx full", v, 32'h00);
    reg_read(3'd3, v); chk("R6 overflow flag", v & 32'h20, 32'h20);
    @(negedge clk); tx_ready = 1'b1;
    repeat (12) @(negedge clk);
    chk("R6 dropped word absent", exp_tx.size(), 0);
    chk("R6 tx idle", {31'b0, tx_valid}, 32'h0);
    tx_ready = 1'b0;

    // R8/R11 transmit trigger 4
    reg_write(3'd0, 32'h80);
    reg_write(3'd3, 32'hFF);
    reg_read(3'd3, v); chk("R11 live source re-sets", v, 32'h02);
    for (int i = 0; i < 5; i++) tx_send(32'hC000_0000 + i, 1'b1);
    reg_write(3'd3, 32'hFF);
    reg_read(3'd3, v); chk("R8 below trigger", v & 32'h02, 32'h0);

    // R5 transmit flush
    reg_write(3'd0, 32'h82);
    reg_read(3'd0, v); chk("R5 tx flush busy", v & 32'h2, 32'h2);
    for (int k = 0; k < 10 && v[1]; k++) reg_read(3'd0, v);
    chk("R5 tx flush clears", v, 32'h80);
    exp_tx.delete();
    reg_read(3'd1, v); chk("R5 tx emptied", v, 32'h80);
    chk("R5 tx no valid", {31'b0, tx_valid}, 32'h0);

    // R3/R7 receive path
    reg_write(3'd0, 32'h00);
    rx_feed(32'h1111_0001); rx_feed(32'h2222_0002); rx_feed(32'h3333_0003);
    reg_read(3'd1, v); chk("R4 rx count", v, 32'h83);
    for (int i = 0; i < 3; i++) begin
      reg_read(3'd5, v); chk("R3 rx order", v, exp_rx.pop_front());
    end
    reg_write(3'd3, 32'hFF);
    reg_read(3'd5, v); chk("R7 empty read", v, 32'h0);
    reg_read(3'd3, v); chk("R7 underflow flag", v & 32'h10, 32'h10);

    // R9 receive trigger 2
    reg_write(3'd0, 32'h08);
    reg_write(3'd3, 32'hFF);
    rx_feed(32'h4); rx_feed(32'h5);
    reg_read(3'd3, v); chk("R9 at trigger", v & 32'h1, 32'h0);
    rx_feed(32'h6);
    reg_read(3'd3, v); chk("R9 above trigger", v & 32'h1, 32'h1);
    for (int i = 0; i < 5; i++) rx_feed(32'h10 + i);
    chk("R3 full not ready", {31'b0, rx_ready}, 32'h0);
    reg_read(3'd1, v); chk("R4 rx full", v, 32'h88);

    // R5 receive flush
    reg_write(3'd0, 32'h09);
    reg_read(3'd0, v);
    for (int k = 0; k < 10 && v[0]; k++) reg_read(3'd0, v);
    chk("R5 rx flush clears", v, 32'h08);
    exp_rx.delete();
    reg_read(3'd1, v); chk("R5 rx emptied", v, 32'h80);
    chk("R5 rx ready again", {31'b0, rx_ready}, 32'h1);

    // R10/R11 events
    reg_write(3'd0, 32'h00);
    reg_write(3'd3, 32'hFF);
    for (int k = 0; k < 4; k++) pulse_ev(k);
    reg_read(3'd3, v); chk("R10 event bits", v & 32'hFC, 32'hCC);
    reg_write(3'd3, 32'h04);
    reg_read(3'd3, v); chk("R11 single clear", v & 32'hFC, 32'hC8);

    // R12 mask
    chk("R12 masked off", {31'b0, irq}, 32'h0);
    reg_write(3'd2, 32'h08);
    chk("R12 nack enabled", {31'b0, irq}, 32'h1);
    reg_write(3'd3, 32'h08);
    chk("R12 cleared", {31'b0, irq}, 32'h0);
    reg_write(3'd2, 32'h02);
    chk("R12 tx request enabled", {31'b0, irq}, 32'h1);
    reg_read(3'd2, v); chk("R12 mask readback", v, 32'h02);

    reg_read(3'd7, v); chk("R1 unused address", v, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule